// File: doc/BRIEF.md
# Reset-Time Configuration Pin Sampler

This block captures a 16-bit system configuration word from a group of port pins while the chip comes out of reset. A reset sequencer supplies three things: a level that stays high for as long as the reset condition lasts, a code that says which kind of reset started it, and a flag that says whether bidirectional reset mode is on. The block keeps the configuration register closed for an initial settling window. After that window it lets a chosen set of bit ranges follow the pins. A fixed number of cycles after reset is released, it takes a final sample that also covers the two low mode bits.

Which bit ranges may follow the pins depends on the reset kind and on bidirectional mode. The delay from release to the final sample depends on the clock option. The captured word stays in a register until the next final sample. It is also decoded into named fields for the clock, bus and startup logic. One clock cycle here stands for one TCL.

Top module: `cfg_pin_sampler`

## Requirements
- R1: After the block's own reset `rstN`, `cfgWord` reads 16'hFFFF, `cfgDone` is low and `normalStart` is high.
- R2: Once `resetHeld` rises, `cfgWord` does not change during the settling window. The window is 2048 cycles for power-on reset (`rstKind` 0) and 1024 cycles for every other kind.
- R3: The final sample is taken DLY_PRESC = 7 cycles after the first clock edge that sees `resetHeld` low when `prescSel` is 1 at that edge, and DLY_DIRECT = 10 cycles otherwise. `cfgDone` is high for exactly the one cycle in which the new word first appears.
- R4: Bits 1:0 of `cfgWord` never follow the pins. They change only at the final sample.
- R5: For power-on (`rstKind` 0), long hardware (1), and any kind with `bidirEn` high, bits 15:2 follow the pins after the settling window, and the final sample loads all 16 bits.
- R6: For a short hardware reset (`rstKind` 2) with `bidirEn` low, only bits 12:2 follow the pins and bits 12:0 are sampled. Bits 15:13 keep their previous values.
- R7: For a watchdog (3) or software (4) reset with `bidirEn` low, only bits 12:6 follow the pins and are sampled. Bits 15:13 and 5:0 keep their previous values. This holds even when reset ends before the settling window does.
- R8: Field positions in `cfgWord`: mode 5:2, bus type 7:6, write configuration 8, chip-select count 10:9, segment lines 12:11, clock configuration 15:13.
- R9: `bootReq` is high exactly when the mode field is 4'b1011. `normalStart` is high exactly when it is 4'b1111.
- R10: Bus type decode: `bus16` is bit 7, so codes 00 and 01 give an 8-bit bus and codes 10 and 11 a 16-bit bus. `busMuxed` is bit 6, so codes 00 and 10 are demultiplexed and codes 01 and 11 are multiplexed.
- R11: `cfgWord` holds its value outside the transparent window and the final sample, including between reset sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per TCL |
| rstN | input | 1 | Asynchronous active-low reset of the block itself |
| resetHeld | input | 1 | High while the chip reset condition lasts |
| rstKind | input | 3 | Reset kind: 0 power-on, 1 long hardware, 2 short hardware, 3 watchdog, 4 software |
| bidirEn | input | 1 | Bidirectional reset mode flag, taken when the reset starts |
| prescSel | input | 1 | Prescaler clock option, taken at release |
| pinsIn | input | 16 | Configuration pin levels |
| cfgWord | output | 16 | Captured configuration word |
| modeSel | output | 4 | Startup mode field |
| busType | output | 2 | Bus type field |
| wrCfg | output | 1 | Write configuration bit |
| csSel | output | 2 | Chip-select count field |
| segSel | output | 2 | Segment address line field |
| clkCfg | output | 3 | Clock configuration field |
| bootReq | output | 1 | Bootstrap loader requested |
| normalStart | output | 1 | Normal start selected |
| bus16 | output | 1 | 16-bit data bus selected |
| busMuxed | output | 1 | Multiplexed addressing selected |
| cfgDone | output | 1 | One-cycle pulse when a new word has been captured |

## Verification
The assertions assume that `resetHeld` stays low from release until the final sample, so a new reset never begins inside the sampling delay. They also assume that `rstKind` and `bidirEn` are valid at the edge where the reset starts. The stimulus waits for `cfgDone` and idles a few cycles before raising `resetHeld` again. It changes `rstKind`, `bidirEn` and `prescSel` only while `resetHeld` is low and the block is idle. The pins are changed inside the settling window, inside the transparent window, and with reset released early, so that every mask and the early-release path are exercised.

// File: rtl/cfgsmp_pkg.sv
package cfgsmp_pkg;

  localparam int CFG_W = 16;

  typedef enum logic [2:0] {
    KIND_POWER = 3'd0,
    KIND_LONG  = 3'd1,
    KIND_SHORT = 3'd2,
    KIND_WDOG  = 3'd3,
    KIND_SOFT  = 3'd4
  } rstKindT;

  // control -> datapath strobes
  typedef struct packed {
    logic             openUpd;
    logic             finalSmp;
    logic [CFG_W-1:0] openMask;
    logic [CFG_W-1:0] finalMask;
  } cfgStrobeT;

  // bits allowed to follow the pins after the settling window
  function automatic logic [CFG_W-1:0] openMaskOf(rstKindT kind, logic bidir);
    if (bidir || kind == KIND_POWER || kind == KIND_LONG) return 16'hFFFC;
    else if (kind == KIND_SHORT)                          return 16'h1FFC;
    else                                                  return 16'h1FC0;
  endfunction

  // bits loaded at the final sample point
  function automatic logic [CFG_W-1:0] finalMaskOf(rstKindT kind, logic bidir);
    if (bidir || kind == KIND_POWER || kind == KIND_LONG) return 16'hFFFF;
    else if (kind == KIND_SHORT)                          return 16'h1FFF;
    else                                                  return 16'h1FC0;
  endfunction

endpackage

// File: rtl/cfgsmp_ctrl.sv
module cfgsmp_ctrl
  import cfgsmp_pkg::*;
#(
  parameter int HOLD_LEN     = 1024,
  parameter int POR_HOLD_LEN = 2048,
  parameter int DLY_PRESC    = 7,
  parameter int DLY_DIRECT   = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       resetHeld,
  input  logic [2:0] rstKind,
  input  logic       bidirEn,
  input  logic       prescSel,
  output cfgStrobeT  stb,
  output logic       cfgDone
);

  localparam int MAX_HOLD = (POR_HOLD_LEN > HOLD_LEN) ? POR_HOLD_LEN : HOLD_LEN;
  localparam int MAX_DLY  = (DLY_DIRECT > DLY_PRESC) ? DLY_DIRECT : DLY_PRESC;
  localparam int MAX_CNT  = (MAX_HOLD > MAX_DLY) ? MAX_HOLD : MAX_DLY;
  localparam int CNT_W    = $clog2(MAX_CNT + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_OPEN, ST_DELAY} stateT;

  stateT            state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] holdLast;
  logic [CNT_W-1:0] dlyLast;
  logic [CNT_W-1:0] dlyPick;
  rstKindT          kindQ;
  logic             bidirQ;
  logic             openSeen;

  assign holdLast = (kindQ == KIND_POWER) ? CNT_W'(POR_HOLD_LEN - 1) : CNT_W'(HOLD_LEN - 1);
  assign dlyPick  = prescSel ? CNT_W'(DLY_PRESC - 1) : CNT_W'(DLY_DIRECT - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      dlyLast  <= '0;
      kindQ    <= KIND_POWER;
      bidirQ   <= 1'b0;
      openSeen <= 1'b0;
      cfgDone  <= 1'b0;
    end else begin
      cfgDone <= 1'b0;
      unique case (state)
        ST_IDLE: if (resetHeld) begin
          state    <= ST_HOLD;
          cnt      <= '0;
          kindQ    <= rstKindT'(rstKind);
          bidirQ   <= bidirEn;
          openSeen <= 1'b0;
        end
        ST_HOLD: begin
          if (!resetHeld) begin
            state   <= ST_DELAY;
            cnt     <= '0;
            dlyLast <= dlyPick;
          end else if (cnt == holdLast) begin
            state    <= ST_OPEN;
            openSeen <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_OPEN: if (!resetHeld) begin
          state   <= ST_DELAY;
          cnt     <= '0;
          dlyLast <= dlyPick;
        end
        ST_DELAY: begin
          if (cnt == dlyLast) begin
            state   <= ST_IDLE;
            cfgDone <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.finalSmp  = (state == ST_DELAY) && (cnt == dlyLast);
    stb.openUpd   = (state == ST_OPEN) ||
                    ((state == ST_DELAY) && openSeen && (cnt != dlyLast));
    stb.openMask  = openMaskOf(kindQ, bidirQ);
    stb.finalMask = finalMaskOf(kindQ, bidirQ);
  end

  // R3: sampling happens only after release has been seen
  p_release_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.finalSmp |-> !resetHeld);

  // R3: completion pulse lasts a single cycle
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |=> !cfgDone);

  // R2: nothing opens in the cycle right after a reset begins
  p_start_closed_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && resetHeld) |=> !stb.openUpd && !stb.finalSmp);

endmodule

// File: rtl/cfgsmp_dpath.sv
module cfgsmp_dpath
  import cfgsmp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobeT        stb,
  input  logic [CFG_W-1:0] pinsIn,
  output logic [CFG_W-1:0] cfgQ,
  output logic [3:0]       modeSel,
  output logic [1:0]       busType,
  output logic             wrCfg,
  output logic [1:0]       csSel,
  output logic [1:0]       segSel,
  output logic [2:0]       clkCfg,
  output logic             bootReq,
  output logic             normalStart,
  output logic             bus16,
  output logic             busMuxed
);

  localparam logic [3:0] MODE_BOOT   = 4'b1011;
  localparam logic [3:0] MODE_NORMAL = 4'b1111;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '1;
    end else if (stb.finalSmp) begin
      cfgQ <= (cfgQ & ~stb.finalMask) | (pinsIn & stb.finalMask);
    end else if (stb.openUpd) begin
      cfgQ <= (cfgQ & ~stb.openMask) | (pinsIn & stb.openMask);
    end
  end

  always_comb begin
    modeSel     = cfgQ[5:2];
    busType     = cfgQ[7:6];
    wrCfg       = cfgQ[8];
    csSel       = cfgQ[10:9];
    segSel      = cfgQ[12:11];
    clkCfg      = cfgQ[15:13];
    bootReq     = (modeSel == MODE_BOOT);
    normalStart = (modeSel == MODE_NORMAL);
    bus16       = busType[1];
    busMuxed    = busType[0];
  end

  // R11: register holds when control issues no strobe
  p_quiet_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.openUpd || stb.finalSmp) |=> $stable(cfgQ));

  // R4: low mode bits move only on the final sample
  p_low_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.finalSmp |=> $stable(cfgQ[1:0]));

  // R6: a sample without the top range leaves clock bits untouched
  p_top_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finalSmp && !stb.finalMask[CFG_W-1]) |=> $stable(cfgQ[CFG_W-1:13]));

  // R9: boot and normal start are never both requested
  p_mode_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(bootReq && normalStart));

endmodule

// File: rtl/cfg_pin_sampler.sv
module cfg_pin_sampler
  import cfgsmp_pkg::*;
#(
  parameter int HOLD_LEN     = 1024,
  parameter int POR_HOLD_LEN = 2048,
  parameter int DLY_PRESC    = 7,
  parameter int DLY_DIRECT   = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        resetHeld,
  input  logic [2:0]  rstKind,
  input  logic        bidirEn,
  input  logic        prescSel,
  input  logic [15:0] pinsIn,
  output logic [15:0] cfgWord,
  output logic [3:0]  modeSel,
  output logic [1:0]  busType,
  output logic        wrCfg,
  output logic [1:0]  csSel,
  output logic [1:0]  segSel,
  output logic [2:0]  clkCfg,
  output logic        bootReq,
  output logic        normalStart,
  output logic        bus16,
  output logic        busMuxed,
  output logic        cfgDone
);

  cfgStrobeT stb;

  cfgsmp_ctrl #(
    .HOLD_LEN    (HOLD_LEN),
    .POR_HOLD_LEN(POR_HOLD_LEN),
    .DLY_PRESC   (DLY_PRESC),
    .DLY_DIRECT  (DLY_DIRECT)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .resetHeld(resetHeld),
    .rstKind  (rstKind),
    .bidirEn  (bidirEn),
    .prescSel (prescSel),
    .stb      (stb),
    .cfgDone  (cfgDone)
  );

  cfgsmp_dpath i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .pinsIn     (pinsIn),
    .cfgQ       (cfgWord),
    .modeSel    (modeSel),
    .busType    (busType),
    .wrCfg      (wrCfg),
    .csSel      (csSel),
    .segSel     (segSel),
    .clkCfg     (clkCfg),
    .bootReq    (bootReq),
    .normalStart(normalStart),
    .bus16      (bus16),
    .busMuxed   (busMuxed)
  );

endmodule

// File: tb/test_cfg_pin_sampler.sv
`timescale 1ns/1ps
module test_cfg_pin_sampler;

  localparam int HOLD_N = 1024;
  localparam int HOLD_P = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetHeld = 1'b0;
  logic [2:0]  rstKind = 3'd0;
  logic        bidirEn = 1'b0;
  logic        prescSel = 1'b0;
  logic [15:0] pinsIn = 16'h0000;
  logic [15:0] cfgWord;
  logic [3:0]  modeSel;
  logic [1:0]  busType, csSel, segSel;
  logic [2:0]  clkCfg;
  logic        wrCfg, bootReq, normalStart, bus16, busMuxed, cfgDone;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  cfg_pin_sampler i_cfg_pin_sampler (
    .clk(clk), .rstN(rstN), .resetHeld(resetHeld), .rstKind(rstKind),
    .bidirEn(bidirEn), .prescSel(prescSel), .pinsIn(pinsIn),
    .cfgWord(cfgWord), .modeSel(modeSel), .busType(busType), .wrCfg(wrCfg),
    .csSel(csSel), .segSel(segSel), .clkCfg(clkCfg), .bootReq(bootReq),
    .normalStart(normalStart), .bus16(bus16), .busMuxed(busMuxed),
    .cfgDone(cfgDone)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // masks derived from R5/R6/R7
  function automatic logic [15:0] openOf(logic [2:0] k, logic b);
    if (b || k == 3'd0 || k == 3'd1) return 16'hFFFC;
    if (k == 3'd2) return 16'h1FFC;
    return 16'h1FC0;
  endfunction
  function automatic logic [15:0] finalOf(logic [2:0] k, logic b);
    if (b || k == 3'd0 || k == 3'd1) return 16'hFFFF;
    if (k == 3'd2) return 16'h1FFF;
    return 16'h1FC0;
  endfunction

  // behavioural reference: edge counts since reset start and since release
  logic [15:0] mCfg;
  logic        mDone;
  bit          mBusy, mRel;
  int          mE, mR, mRelAt, mDly, mHold;
  logic [2:0]  mKind;
  logic        mBidir;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mCfg = 16'hFFFF; mDone = 1'b0; mBusy = 0; mRel = 0;
    end else begin
      mDone = 1'b0;
      if (!mBusy) begin
        if (resetHeld) begin
          mBusy = 1; mRel = 0; mE = 0; mKind = rstKind; mBidir = bidirEn;
          mHold = (rstKind == 3'd0) ? HOLD_P : HOLD_N;
        end
      end else begin
        mE++;
        if (!mRel) begin
          if (mE > mHold)
            mCfg = (mCfg & ~openOf(mKind, mBidir)) | (pinsIn & openOf(mKind, mBidir));
          if (!resetHeld) begin
            mRel = 1; mR = 0; mRelAt = mE; mDly = prescSel ? 7 : 10;
          end
        end else begin
          mR++;
          if (mR == mDly) begin
            mCfg = (mCfg & ~finalOf(mKind, mBidir)) | (pinsIn & finalOf(mKind, mBidir));
            mBusy = 0; mDone = 1'b1;
          end else if (mRelAt > mHold) begin
            mCfg = (mCfg & ~openOf(mKind, mBidir)) | (pinsIn & openOf(mKind, mBidir));
          end
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && cycles > 2) begin
      chk(cfgWord == mCfg, "R11 word", cfgWord, mCfg);
      chk(cfgDone == mDone, "R3 done", {15'd0, cfgDone}, {15'd0, mDone});
      chk({clkCfg, segSel, csSel, wrCfg, busType, modeSel} == mCfg[15:2],
          "R8 fields", {2'b0, clkCfg, segSel, csSel, wrCfg, busType, modeSel},
          {2'b0, mCfg[15:2]});
    end
  end

  always @(posedge clk) begin
    if (cycles > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic runSeq(input logic [2:0] k, input logic b, input logic p,
                        input int held, input logic [15:0] pHold,
                        input logic [15:0] pOpen, input logic [15:0] expFinal,
                        input string req);
    logic [15:0] prev;
    int hold, n;
    hold = (k == 3'd0) ? HOLD_P : HOLD_N;
    @(negedge clk);
    prev = cfgWord;
    rstKind = k; bidirEn = b; pinsIn = pHold; resetHeld = 1'b1;
    repeat (held / 2) @(negedge clk);
    chk(cfgWord == prev, "R2 frozen in settling window", cfgWord, prev);
    if (held > hold) begin
      repeat (held - held / 2 - 4) @(negedge clk);
      pinsIn = pOpen;
      repeat (3) @(negedge clk);
      chk(cfgWord == ((prev & ~openOf(k, b)) | (pOpen & openOf(k, b))),
          {req, " transparent"}, cfgWord,
          (prev & ~openOf(k, b)) | (pOpen & openOf(k, b)));
      chk(cfgWord[1:0] == prev[1:0], "R4 low bits closed",
          {14'd0, cfgWord[1:0]}, {14'd0, prev[1:0]});
    end else begin
      repeat (held - held / 2) @(negedge clk);
      pinsIn = pOpen;
    end
    resetHeld = 1'b0; prescSel = p;
    n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (!cfgDone && n < 40);
    chk(n == (p ? 8 : 11), "R3 sample delay", 16'(n), p ? 16'd8 : 16'd11);
    chk(cfgWord == expFinal, req, cfgWord, expFinal);
    repeat (4) @(negedge clk);
    chk(cfgWord == expFinal, "R11 held after sample", cfgWord, expFinal);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(cfgWord == 16'hFFFF, "R1 reset word", cfgWord, 16'hFFFF);
    chk(!cfgDone && normalStart, "R1 done/normal", {14'd0, cfgDone, normalStart},
        16'h0001);

    // power-on, direct clock: full capture, boot mode
    runSeq(3'd0, 1'b0, 1'b0, HOLD_P + 20, 16'h0000, 16'h72AE, 16'h72AE, "R5 power-on");
    chk(bootReq && !normalStart, "R9 boot decode", {14'd0, bootReq, normalStart}, 16'h0002);
    chk(modeSel == 4'b1011 && clkCfg == 3'b011 && segSel == 2'b10 && csSel == 2'b01
        && !wrCfg, "R8 field positions", cfgWord, 16'h72AE);
    chk(bus16 && !busMuxed, "R10 bus 16 demux", {14'd0, bus16, busMuxed}, 16'h0002);

    // short hardware, prescaler: top bits kept
    runSeq(3'd2, 1'b0, 1'b1, HOLD_N + 20, 16'hFFFF, 16'h8D53, 16'h6D53, "R6 short hw");
    chk(!bus16 && busMuxed, "R10 bus 8 mux", {14'd0, bus16, busMuxed}, 16'h0001);

    // software, direct clock: only middle range
    runSeq(3'd4, 1'b0, 1'b0, HOLD_N + 20, 16'h0000, 16'hFFFF, 16'h7FD3, "R7 software");

    // watchdog with bidirectional mode: full capture
    runSeq(3'd3, 1'b1, 1'b1, HOLD_N + 20, 16'h0000, 16'h3C3D, 16'h3C3D, "R5 bidir watchdog");

    // long hardware: normal start
    runSeq(3'd1, 1'b0, 1'b0, HOLD_N + 40, 16'h1234, 16'hFFFF, 16'hFFFF, "R5 long hw");
    chk(normalStart && !bootReq, "R9 normal decode", {14'd0, bootReq, normalStart}, 16'h0001);

    // software released inside settling window: only final sample of 12:6
    runSeq(3'd4, 1'b0, 1'b1, 300, 16'hAAAA, 16'h0000, 16'hE03F, "R7 early release");

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule